// File: doc/BRIEF.md
# Link Idle Inactivity Timeout Controller

This block measures how long a serial link port has been idle and decides when the port should ask to leave the active state for a low-power state. It holds two programmable timeout codes. The first-level code times idleness in the active state and leads to a request for the shallow sleep state. The second-level code times residence in the shallow sleep state and leads to a silent drop into the deeper sleep state, with no handshake. A configuration interface writes both codes. Request strobes go to a separate negotiation block, which performs the actual state handshake.

All timing is derived from a one-pulse-per-microsecond tick. The first-level timer counts microsecond ticks directly. The second-level timer counts a prescaled tick, so that an 8-bit code can reach tens of milliseconds. Per-state enable inputs decide which requests are allowed. A first-level code strictly between zero and all-ones also grants permission for both states without the enable inputs. When only the deeper state is allowed, the active-state timer uses the second-level code and requests the deeper state directly.

Top module: `idle_lpm_timer`

## Requirements
- R1: After reset both timeout codes hold all-ones (timer off), so no strobe appears even with both enables set and the link idle in the active state. All outputs are low during and after reset.
- R2: With the shallow state allowed and a first-level code N from 1 to 0xFE, `req_u1_o` pulses for one cycle once the link has been idle for N microsecond ticks. Writing such a code grants permission for both states on its own, even with `u1_en_i` and `u2_en_i` low.
- R3: Any cycle with `link_busy_i` high reloads the active-state timer, and the count starts again from zero.
- R4: A first-level code of 0 raises the request on the first idle cycle, before any tick.
- R5: A first-level code of all-ones (0xFF) switches off the shallow-state request entirely.
- R6: No request strobe is raised while `pending_i` is high. If the timer has already expired when `pending_i` falls, the strobe follows within two cycles.
- R7: Each timer gives at most one strobe per idle period. It re-arms only after activity, a state change or a configuration write.
- R8: On entry to the shallow state (`link_state_i` = 1), the second timer starts. `demote_u2_o` pulses after code2 x PRESCALE microsecond ticks.
- R9: With the shallow state not allowed and the deeper state allowed, idleness in the active state leads to `req_u2_o` after code2 x PRESCALE ticks, and `req_u1_o` stays low.
- R10: With neither state allowed, the active-state timer raises nothing.
- R11: The silent demotion needs the deeper state to be allowed and a second-level code other than 0xFF.
- R12: Link state encoding is 0 active, 1 shallow sleep, 2 deep sleep, 3 suspend. Request strobes occur only in state 0. The demotion strobe occurs only in state 1. In state 2 or 3 nothing is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| cfg_wr_i | input | 1 | Timeout code write strobe |
| cfg_sel_i | input | 1 | 0 selects first-level code, 1 selects second-level code |
| cfg_data_i | input | CODE_W | Timeout code to write |
| u1_en_i | input | 1 | Shallow sleep request allowed |
| u2_en_i | input | 1 | Deep sleep request allowed |
| link_state_i | input | 2 | Current link state (0..3) |
| link_busy_i | input | 1 | Link activity in the current cycle |
| pending_i | input | 1 | Traffic, acknowledgements or credits still outstanding |
| req_u1_o | output | 1 | Request shallow sleep entry (strobe) |
| req_u2_o | output | 1 | Request deep sleep entry from active (strobe) |
| demote_u2_o | output | 1 | Silent shallow-to-deep demotion (strobe) |

## Verification
The bench builds the block with PRESCALE = 4 and keeps CODE_W at 8, and it issues a microsecond tick every fourth clock. With these settings the coarse-unit timers expire within a few dozen ticks, so the direct deep-state request and the silent demotion can be timed exactly to the tick, alongside the fine-unit path. Tick-accurate counts make off-by-one faults in the reload, the prescaler and the expiry compare visible.

// File: rtl/idle_lpm_pkg.sv
package idle_lpm_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE  = 2'd0,
    LS_SHALLOW = 2'd1,
    LS_DEEP    = 2'd2,
    LS_SUSPEND = 2'd3
  } link_st_e;

  function automatic logic code_is_off(input logic [7:0] code);
    return &code;
  endfunction
endpackage

// File: rtl/lpm_timeout_regs.sv
module lpm_timeout_regs #(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code1_o,
  output logic [CODE_W-1:0] code2_o,
  output logic              impl_en_o
);
  logic [CODE_W-1:0] code1_q, code2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code1_q <= '1;
      code2_q <= '1;
    end else if (wr_i) begin
      if (sel_i) code2_q <= data_i;
      else       code1_q <= data_i;
    end
  end

  assign code1_o   = code1_q;
  assign code2_o   = code2_q;
  // mid-range first-level code implies permission
  assign impl_en_o = (code1_q != '0) && !(&code1_q);

  a_r1_reset_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(code1_q) && $stable(code2_q));
endmodule

// File: rtl/lpm_idle_cnt.sv
module lpm_idle_cnt #(
  parameter int CODE_W   = 8,
  parameter int PRESCALE = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              coarse_i,
  input  logic              us_tick_i,
  input  logic              gate_i,
  input  logic [CODE_W-1:0] limit_i,
  output logic              fire_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              fired_q;
  logic              coarse_tick, tick_eff, off, expired;

  generate
    if (PRESCALE > 1) begin : g_ps
      localparam int PS_W = $clog2(PRESCALE);
      logic [PS_W-1:0] ps_q;
      logic            wrap;
      assign wrap = (ps_q == PS_W'(PRESCALE - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 ps_q <= '0;
        else if (clr_i)              ps_q <= '0;
        else if (run_i && us_tick_i) ps_q <= wrap ? '0 : ps_q + PS_W'(1);
      end
      assign coarse_tick = us_tick_i & wrap;
    end else begin : g_nops
      assign coarse_tick = us_tick_i;
    end
  endgenerate

  assign tick_eff = coarse_i ? coarse_tick : us_tick_i;
  assign off      = &limit_i;
  assign expired  = !off && (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clr_i)                             cnt_q <= '0;
    else if (run_i && tick_eff && !expired && !off) cnt_q <= cnt_q + CODE_W'(1);
  end

  assign fire_o = run_i & gate_i & expired & !fired_q & !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fired_q <= 1'b0;
    else if (clr_i)  fired_q <= 1'b0;
    else if (fire_o) fired_q <= 1'b1;
  end

  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CODE_W'(1)));
  a_r7_fire_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/idle_lpm_timer.sv
module idle_lpm_timer
  import idle_lpm_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int PRESCALE = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [CODE_W-1:0] cfg_data_i,
  input  logic              u1_en_i,
  input  logic              u2_en_i,
  input  logic [1:0]        link_state_i,
  input  logic              link_busy_i,
  input  logic              pending_i,
  output logic              req_u1_o,
  output logic              req_u2_o,
  output logic              demote_u2_o
);
  logic [CODE_W-1:0] code1, code2;
  logic              impl_en, u1_ok, u2_ok, direct_u2, direct_q;
  logic              in_active, in_shallow;
  logic              act_clr, act_run, act_fire;
  logic              slp_clr, slp_run, slp_fire;
  logic [CODE_W-1:0] act_limit;
  logic              req_u1_q, req_u2_q, demote_q;
  link_st_e          st;

  lpm_timeout_regs #(.CODE_W(CODE_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .code1_o  (code1),
    .code2_o  (code2),
    .impl_en_o(impl_en)
  );

  assign st         = link_st_e'(link_state_i);
  assign in_active  = (st == LS_ACTIVE);
  assign in_shallow = (st == LS_SHALLOW);
  assign u1_ok      = u1_en_i | impl_en;
  assign u2_ok      = u2_en_i | impl_en;
  assign direct_u2  = !u1_ok & u2_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) direct_q <= 1'b0;
    else         direct_q <= direct_u2;
  end

  // active-state timer: reload on activity, state change, reconfig or target switch
  assign act_clr   = !in_active | link_busy_i | cfg_wr_i | (direct_q != direct_u2);
  assign act_run   = in_active & (u1_ok | u2_ok);
  assign act_limit = direct_u2 ? code2 : code1;

  lpm_idle_cnt #(.CODE_W(CODE_W), .PRESCALE(PRESCALE)) u_act_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (act_clr),
    .run_i    (act_run),
    .coarse_i (direct_u2),
    .us_tick_i(us_tick_i),
    .gate_i   (!pending_i),
    .limit_i  (act_limit),
    .fire_o   (act_fire)
  );

  // shallow-state residence timer for silent demotion
  assign slp_clr = !in_shallow | cfg_wr_i;
  assign slp_run = in_shallow & u2_ok;

  lpm_idle_cnt #(.CODE_W(CODE_W), .PRESCALE(PRESCALE)) u_slp_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (slp_clr),
    .run_i    (slp_run),
    .coarse_i (1'b1),
    .us_tick_i(us_tick_i),
    .gate_i   (1'b1),
    .limit_i  (code2),
    .fire_o   (slp_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_u1_q <= 1'b0;
      req_u2_q <= 1'b0;
      demote_q <= 1'b0;
    end else begin
      req_u1_q <= act_fire & !direct_u2;
      req_u2_q <= act_fire & direct_u2;
      demote_q <= slp_fire;
    end
  end

  assign req_u1_o    = req_u1_q;
  assign req_u2_o    = req_u2_q;
  assign demote_u2_o = demote_q;

  a_r6_no_req_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_u1_o | req_u2_o) |-> $past(!pending_i));
  a_r12_req_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_u1_o | req_u2_o) |-> $past(link_state_i == 2'd0));
  a_r12_demote_in_shallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demote_u2_o |-> $past(link_state_i == 2'd1));
  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_u1_o, req_u2_o, demote_u2_o}));
  a_r10_u1_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_u1_o |-> $past(u1_ok));
  a_r11_u2_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_u2_o | demote_u2_o) |-> $past(u2_ok));
endmodule

// File: tb/idle_lpm_timer_bench.sv
module idle_lpm_timer_bench;
  localparam int PS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       us_tick_i = 1'b0;
  logic       cfg_wr_i = 1'b0;
  logic       cfg_sel_i = 1'b0;
  logic [7:0] cfg_data_i = '0;
  logic       u1_en_i = 1'b0;
  logic       u2_en_i = 1'b0;
  logic [1:0] link_state_i = 2'd0;
  logic       link_busy_i = 1'b1;
  logic       pending_i = 1'b0;
  logic       req_u1_o, req_u2_o, demote_u2_o;

  idle_lpm_timer #(.CODE_W(8), .PRESCALE(PS)) u_idle_lpm_timer (
    .clk_i, .rst_ni, .us_tick_i, .cfg_wr_i, .cfg_sel_i, .cfg_data_i,
    .u1_en_i, .u2_en_i, .link_state_i, .link_busy_i, .pending_i,
    .req_u1_o, .req_u2_o, .demote_u2_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int ph = 0, ticks_seen = 0;
  int n_u1 = 0, n_u2 = 0, n_dm = 0, first_kind = 0, first_ticks = -1;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0] c1;
    logic [7:0] c2;
    logic       u1;
    logic       u2;
    logic [1:0] st;
    logic [1:0] kind;   // 0 none, 1 req_u1, 2 req_u2, 3 demote
    logic [7:0] ticks;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h05, 8'hFF, 1'b0, 1'b0, 2'd0, 2'd1, 8'd5,  4'd2},  // R2 implicit enable
    '{8'h00, 8'hFF, 1'b1, 1'b0, 2'd0, 2'd1, 8'd0,  4'd4},  // R4 zero code
    '{8'hFF, 8'hFF, 1'b1, 1'b1, 2'd0, 2'd0, 8'd0,  4'd5},  // R5 code off
    '{8'hFF, 8'h03, 1'b0, 1'b1, 2'd0, 2'd2, 8'd12, 4'd9},  // R9 direct deep
    '{8'h00, 8'h03, 1'b0, 1'b0, 2'd0, 2'd0, 8'd0,  4'd10}, // R10 nothing allowed
    '{8'h07, 8'h02, 1'b0, 1'b0, 2'd1, 2'd3, 8'd8,  4'd8},  // R8 demotion
    '{8'hFF, 8'h02, 1'b1, 1'b0, 2'd1, 2'd0, 8'd0,  4'd11}, // R11 deep not allowed
    '{8'hFF, 8'hFF, 1'b0, 1'b1, 2'd1, 2'd0, 8'd0,  4'd11}, // R11 code off
    '{8'h14, 8'h01, 1'b1, 1'b1, 2'd2, 2'd0, 8'd0,  4'd12}  // R12 deep state silent
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    if (req_u1_o) begin n_u1++; if (first_kind == 0) begin first_kind = 1; first_ticks = ticks_seen; end end
    if (req_u2_o) begin n_u2++; if (first_kind == 0) begin first_kind = 2; first_ticks = ticks_seen; end end
    if (demote_u2_o) begin n_dm++; if (first_kind == 0) begin first_kind = 3; first_ticks = ticks_seen; end end
    us_tick_i = (ph % 4 == 0);
    if (us_tick_i) ticks_seen++;
    ph++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    step();
    cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d;
    step();
    cfg_wr_i = 1'b0;
  endtask

  task automatic park();
    step();
    link_busy_i = 1'b1; link_state_i = 2'd0;
    steps(3);
  endtask

  task automatic go_idle(input logic [1:0] st);
    do step(); while (us_tick_i);
    link_busy_i = 1'b0; link_state_i = st;
    n_u1 = 0; n_u2 = 0; n_dm = 0; first_kind = 0; first_ticks = -1; ticks_seen = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    steps(3);
    // R1: outputs low during reset
    chk(!req_u1_o && !req_u2_o && !demote_u2_o, "R1 in reset", int'({req_u1_o, req_u2_o, demote_u2_o}), 0);
    rst_ni = 1'b1;
    steps(2);
    chk(!req_u1_o && !req_u2_o && !demote_u2_o, "R1 after reset", int'({req_u1_o, req_u2_o, demote_u2_o}), 0);
    // R1: default codes are off
    u1_en_i = 1'b1; u2_en_i = 1'b1;
    go_idle(2'd0);
    steps(200);
    chk(n_u1 + n_u2 + n_dm == 0, "R1 default off", n_u1 + n_u2 + n_dm, 0);
    park();

    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VECS[v].c1);
      wr(1'b1, VECS[v].c2);
      u1_en_i = VECS[v].u1; u2_en_i = VECS[v].u2;
      go_idle(VECS[v].st);
      steps(300);
      if (VECS[v].kind == 2'd0) begin
        chk(n_u1 + n_u2 + n_dm == 0, $sformatf("R%0d vec%0d silent", VECS[v].req, v),
            n_u1 + n_u2 + n_dm, 0);
      end else begin
        chk(first_kind == int'(VECS[v].kind), $sformatf("R%0d vec%0d kind", VECS[v].req, v),
            first_kind, int'(VECS[v].kind));
        chk(first_ticks == int'(VECS[v].ticks), $sformatf("R%0d vec%0d ticks", VECS[v].req, v),
            first_ticks, int'(VECS[v].ticks));
        // R7: one strobe per idle period
        chk(n_u1 + n_u2 + n_dm == 1, $sformatf("R7 vec%0d single strobe", v),
            n_u1 + n_u2 + n_dm, 1);
      end
      park();
    end

    // R3: activity reloads the count
    wr(1'b0, 8'd10); wr(1'b1, 8'hFF);
    u1_en_i = 1'b1; u2_en_i = 1'b0;
    go_idle(2'd0);
    while (ticks_seen < 6) step();
    chk(n_u1 == 0, "R3 no early request", n_u1, 0);
    link_busy_i = 1'b1;
    steps(2);
    go_idle(2'd0);
    steps(200);
    chk(first_ticks == 10, "R3 reload restarts count", first_ticks, 10);
    chk(n_u1 == 1, "R3 single request", n_u1, 1);
    park();

    // R6: pending blocks the request
    wr(1'b0, 8'd3);
    pending_i = 1'b1;
    go_idle(2'd0);
    while (ticks_seen < 8) step();
    chk(n_u1 == 0, "R6 held while pending", n_u1, 0);
    pending_i = 1'b0;
    steps(3);
    chk(n_u1 == 1, "R6 released after pending", n_u1, 1);
    steps(100);
    chk(n_u1 == 1, "R7 no repeat", n_u1, 1);
    park();

    // R12: shallow state never yields active-state requests
    wr(1'b0, 8'd2); wr(1'b1, 8'hFF);
    go_idle(2'd1);
    steps(100);
    chk(n_u1 + n_u2 == 0, "R12 no request outside active", n_u1 + n_u2, 0);
    park();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule